// File: doc/BRIEF.md
# Radar pulse timing sequencer

This block produces the repeating timing frame of a monostatic pulsed radar. Every frame runs four phases in a fixed order: the transmitter is keyed, the front end then switches from transmit to receive, a receive window is opened for echo sampling, and an idle gap fills out the remaining time before the next pulse. Each phase length comes from its own programmable interval register. That register holds the wanted length in sample clocks minus one. A one-cycle pulse-start strobe marks the first clock of every frame so that a chirp generator can restart its sweep.

Software programs the block through a simple address/data/strobe write port. The mode word sits on the same port. Its hold bit keeps the whole sequencer parked with every strobe low. Its side bit steers the transmitter to one of two sides. Its debug bit exposes the current phase on a small output. Interval writes are staged and only take effect when the next frame starts, so a frame that is already running always finishes with the lengths it began with.

Top module: `radar_pulse_sequencer`

## Requirements
- R1: After `rst`, `mode_rd` reads 8'h01 (hold set), the staged and active intervals are zero, and `tx_en`, `rx_window`, `pulse_start` and `dbg_phase` are all low.
- R2: While running, the phases follow transmit-on, switch, receive-look, idle and then repeat. A phase whose register holds value v lasts v+1 clocks, a register value of zero gives one clock, and `tx_en` is high only during transmit-on.
- R3: The distance between consecutive `pulse_start` strobes is on+switch+look+idle+4 clocks. `pulse_start` is high for exactly one clock, on the first transmit-on clock of each frame.
- R4: `rx_window` is high for exactly look+1 consecutive clocks per frame and is never high together with `tx_en`.
- R5: Mode bit 0 is the hold bit. From the second clock after a write that sets it, all strobes stay low for as long as it stays set. After a write that clears it, `tx_en` and `pulse_start` rise on the second clock after the write strobe.
- R6: `tx_side` equals mode bit 1 from the clock after the mode write. It changes no frame timing.
- R7: With mode bit 7 set, `dbg_phase` shows the current phase as 0 parked, 1 transmit-on, 2 switch, 3 look, 4 idle. With bit 7 clear it reads 0.
- R8: A write to an interval register while a frame is running leaves that frame unchanged. The new value governs the next frame.
- R9: Mode bits 6:2 read back on `mode_rd` exactly as written and have no effect on any strobe or on timing.
- R10: Register addresses are 0 mode, 1 transmit-on, 2 switch, 3 look, 4 idle. The first three keep `wr_data[15:0]`, idle keeps `wr_data[31:0]` and mode keeps `wr_data[7:0]`. Writes to addresses 5 to 7 change nothing.
- R11: Interval writes made while the hold bit is set govern the first frame after the hold bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| tx_en | output | 1 | Transmit-enable strobe |
| tx_side | output | 1 | Transmit side select |
| rx_window | output | 1 | Receive-window strobe |
| pulse_start | output | 1 | One-cycle strobe on the first clock of each frame |
| dbg_phase | output | 3 | Phase code when debug is enabled, otherwise 0 |
| mode_rd | output | 8 | Current mode word |

## Verification
A write sampled at clock edge k shows up on `mode_rd` and `tx_side` after edge k. The hold bit takes effect on the strobes one edge later, at k+1. This holds both ways, so after a release `pulse_start` rises after edge k+1. An interval write shows up only at the next frame boundary. A behavioural model in the bench follows the same edge counts and is compared with every output at each falling edge, so each result is checked in exactly the cycle it is due. Scenario checks also time the gaps between pulse strobes and count window lengths, including frames that have a write in flight.

// File: rtl/rps_pkg.sv
package rps_pkg;

    localparam int TIME_SHORT_W = 16;
    localparam int TIME_LONG_W  = 32;
    localparam int MODE_W       = 8;
    localparam int PHASE_W      = 3;

    // register addresses
    localparam int RA_MODE = 0;
    localparam int RA_ON   = 1;
    localparam int RA_SW   = 2;
    localparam int RA_LOOK = 3;
    localparam int RA_IDLE = 4;

    typedef enum logic [PHASE_W-1:0] {
        PH_OFF  = 3'd0,
        PH_ON   = 3'd1,
        PH_SW   = 3'd2,
        PH_LOOK = 3'd3,
        PH_IDLE = 3'd4
    } phase_e;

    typedef struct packed {
        logic       debug;
        logic [4:0] spare;
        logic       side;
        logic       hold;
    } mode_t;

    typedef struct packed {
        logic [TIME_SHORT_W-1:0] on_len;
        logic [TIME_SHORT_W-1:0] sw_len;
        logic [TIME_SHORT_W-1:0] look_len;
        logic [TIME_LONG_W-1:0]  idle_len;
    } intervals_t;

    localparam mode_t MODE_RESET = '{debug: 1'b0, spare: 5'd0, side: 1'b0, hold: 1'b1};

    function automatic phase_e phase_succ(input phase_e p);
        case (p)
            PH_ON:   return PH_SW;
            PH_SW:   return PH_LOOK;
            PH_LOOK: return PH_IDLE;
            default: return PH_ON;
        endcase
    endfunction

    function automatic logic [TIME_LONG_W-1:0] widen(input logic [TIME_SHORT_W-1:0] v);
        return {{(TIME_LONG_W-TIME_SHORT_W){1'b0}}, v};
    endfunction

    function automatic logic [TIME_LONG_W-1:0] interval_for(input intervals_t iv, input phase_e p);
        case (p)
            PH_ON:   return widen(iv.on_len);
            PH_SW:   return widen(iv.sw_len);
            PH_LOOK: return widen(iv.look_len);
            default: return iv.idle_len;
        endcase
    endfunction

endpackage

// File: rtl/rps_regfile.sv
module rps_regfile
    import rps_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [TIME_LONG_W-1:0] wr_data,
    output mode_t                  mode_q,
    output intervals_t             stage_q
);

    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(RA_MODE);
    localparam logic [ADDR_W-1:0] A_ON   = ADDR_W'(RA_ON);
    localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(RA_SW);
    localparam logic [ADDR_W-1:0] A_LOOK = ADDR_W'(RA_LOOK);
    localparam logic [ADDR_W-1:0] A_IDLE = ADDR_W'(RA_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_RESET;
            stage_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_MODE:  mode_q           <= mode_t'(wr_data[MODE_W-1:0]);
                A_ON:    stage_q.on_len   <= wr_data[TIME_SHORT_W-1:0];
                A_SW:    stage_q.sw_len   <= wr_data[TIME_SHORT_W-1:0];
                A_LOOK:  stage_q.look_len <= wr_data[TIME_SHORT_W-1:0];
                A_IDLE:  stage_q.idle_len <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rps_frame_ctrl.sv
module rps_frame_ctrl
    import rps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  intervals_t stage_q,
    output phase_e     phase_q,
    output logic       start_q
);

    intervals_t             active_q;
    logic [TIME_LONG_W-1:0] cnt_q;
    logic [TIME_LONG_W-1:0] limit;
    logic                   phase_done;

    always_comb begin
        limit      = interval_for(active_q, phase_q);
        phase_done = (cnt_q == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_OFF;
            cnt_q    <= '0;
            start_q  <= 1'b0;
            active_q <= '0;
        end else if (hold) begin
            phase_q <= PH_OFF;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (phase_q == PH_OFF) begin
                phase_q  <= PH_ON;
                cnt_q    <= '0;
                active_q <= stage_q;
                start_q  <= 1'b1;
            end else if (phase_done) begin
                phase_q <= phase_succ(phase_q);
                cnt_q   <= '0;
                if (phase_q == PH_IDLE) begin
                    active_q <= stage_q;
                    start_q  <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rps_out_decode.sv
module rps_out_decode
    import rps_pkg::*;
(
    input  phase_e             phase_q,
    input  logic               start_q,
    input  mode_t              mode_q,
    output logic               tx_en,
    output logic               tx_side,
    output logic               rx_window,
    output logic               pulse_start,
    output logic [PHASE_W-1:0] dbg_phase,
    output logic [MODE_W-1:0]  mode_rd
);

    always_comb begin
        tx_en       = (phase_q == PH_ON);
        rx_window   = (phase_q == PH_LOOK);
        pulse_start = start_q;
        tx_side     = mode_q.side;
        dbg_phase   = mode_q.debug ? phase_q : '0;
        mode_rd     = mode_q;
    end

endmodule

// File: rtl/radar_pulse_sequencer.sv
module radar_pulse_sequencer
    import rps_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [TIME_LONG_W-1:0] wr_data,
    output logic                   tx_en,
    output logic                   tx_side,
    output logic                   rx_window,
    output logic                   pulse_start,
    output logic [PHASE_W-1:0]     dbg_phase,
    output logic [MODE_W-1:0]      mode_rd
);

    mode_t      mode_q;
    intervals_t stage_q;
    phase_e     phase_q;
    logic       start_q;

    rps_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode_q  (mode_q),
        .stage_q (stage_q)
    );

    rps_frame_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .hold    (mode_q.hold),
        .stage_q (stage_q),
        .phase_q (phase_q),
        .start_q (start_q)
    );

    rps_out_decode u_out (
        .phase_q     (phase_q),
        .start_q     (start_q),
        .mode_q      (mode_q),
        .tx_en       (tx_en),
        .tx_side     (tx_side),
        .rx_window   (rx_window),
        .pulse_start (pulse_start),
        .dbg_phase   (dbg_phase),
        .mode_rd     (mode_rd)
    );

endmodule

// File: rtl/rps_checker.sv
module rps_checker (
    input logic       clk,
    input logic       rst,
    input logic       tx_en,
    input logic       rx_window,
    input logic       pulse_start,
    input logic [2:0] dbg_phase,
    input logic [7:0] mode_rd
);

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_en && rx_window));

    // R3
    pulse_in_tx_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_start |-> tx_en);

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_start |=> !pulse_start);

    // R2
    switch_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_window) |-> !$past(tx_en));

    // R5
    held_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mode_rd[0]) |-> (!tx_en && !rx_window && !pulse_start));

    // R7
    dbg_off_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_rd[7] |-> (dbg_phase == 3'd0));

    // R7
    dbg_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_rd[7] && tx_en) |-> (dbg_phase == 3'd1));

endmodule

bind radar_pulse_sequencer rps_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_en       (tx_en),
    .rx_window   (rx_window),
    .pulse_start (pulse_start),
    .dbg_phase   (dbg_phase),
    .mode_rd     (mode_rd)
);

// File: tb/radar_pulse_sequencer_bench.sv
`timescale 1ns/1ps
module radar_pulse_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tx_en, tx_side, rx_window, pulse_start;
    logic [2:0]  dbg_phase;
    logic [7:0]  mode_rd;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    radar_pulse_sequencer u_radar_pulse_sequencer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_en(tx_en), .tx_side(tx_side), .rx_window(rx_window),
        .pulse_start(pulse_start), .dbg_phase(dbg_phase), .mode_rd(mode_rd)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    longint m_mode, m_stg[5], m_act[5], m_ph, m_cnt;
    bit     m_first;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_mode = 1; m_ph = 0; m_cnt = 0; m_first = 0;
            for (int i = 0; i < 5; i++) begin m_stg[i] = 0; m_act[i] = 0; end
        end else begin
            longint old_mode;
            longint old_stg[5];
            old_mode = m_mode;
            old_stg = m_stg;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_mode = wr_data & 8'hFF;
                    3'd1, 3'd2, 3'd3: m_stg[wr_addr] = wr_data & 16'hFFFF;
                    3'd4: m_stg[4] = wr_data;
                    default: ;
                endcase
            end
            m_first = 0;
            if (old_mode[0]) begin
                m_ph = 0; m_cnt = 0;
            end else if (m_ph == 0) begin
                m_ph = 1; m_cnt = 0; m_act = old_stg; m_first = 1;
            end else if (m_cnt == m_act[m_ph]) begin
                m_cnt = 0;
                if (m_ph == 4) begin
                    m_ph = 1; m_act = old_stg; m_first = 1;
                end else m_ph = m_ph + 1;
            end else m_cnt++;
        end
    end

    always @(negedge clk) begin
        if (model_on && !done) begin
            chk("R2", "tx_en", tx_en, m_ph == 1);
            chk("R4", "rx_window", rx_window, m_ph == 3);
            chk("R3", "pulse_start", pulse_start, m_first);
            chk("R6", "tx_side", tx_side, m_mode[1]);
            chk("R7", "dbg_phase", dbg_phase, m_mode[7] ? m_ph : 0);
            chk("R9", "mode_rd", mode_rd, m_mode);
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse(output int t);
        do @(negedge clk); while (!pulse_start);
        t = cyc;
    endtask

    task automatic frame_stats(output int per, output int ntx, output int nrx);
        int t;
        wait_pulse(t);
        per = 1; ntx = 1; nrx = 0;
        forever begin
            @(negedge clk);
            if (pulse_start) break;
            per++;
            ntx += tx_en;
            nrx += rx_window;
        end
    endtask

    initial begin
        #(8.0 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int per, ntx, nrx, t0, t1, t2;
        bit quiet;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "mode_rd", mode_rd, 8'h01);
        chk("R1", "tx_en", tx_en, 0);
        chk("R1", "rx_window", rx_window, 0);
        chk("R1", "pulse_start", pulse_start, 0);
        chk("R1", "dbg_phase", dbg_phase, 0);
        model_on = 1'b1;

        reg_write(3'd1, 32'd3);
        reg_write(3'd2, 32'd1);
        reg_write(3'd3, 32'd5);
        reg_write(3'd4, 32'd9);
        reg_write(3'd0, 32'd0);
        // R5 release: still quiet one clock after the write
        chk("R5", "tx_en after release write", tx_en, 0);
        @(negedge clk);
        chk("R5", "tx_en second clock", tx_en, 1);
        chk("R5", "pulse_start second clock", pulse_start, 1);

        // R2 R3 R4 frame shape
        frame_stats(per, ntx, nrx);
        chk("R3", "period", per, 22);
        chk("R2", "tx length", ntx, 4);
        chk("R4", "rx length", nrx, 6);

        // R8 mid-frame write
        wait_pulse(t0);
        reg_write(3'd1, 32'd7);
        wait_pulse(t1);
        wait_pulse(t2);
        chk("R8", "running frame period", t1 - t0, 22);
        chk("R8", "next frame period", t2 - t1, 26);

        // R6 side select
        reg_write(3'd0, 32'h02);
        chk("R6", "tx_side", tx_side, 1);

        // R7 debug view
        reg_write(3'd0, 32'h82);
        wait_pulse(t0);
        chk("R7", "dbg_phase at pulse", dbg_phase, 1);

        // R9 spare bits
        reg_write(3'd0, 32'h7E);
        chk("R9", "mode readback", mode_rd, 8'h7E);
        wait_pulse(t0);
        wait_pulse(t1);
        chk("R9", "period with spare bits", t1 - t0, 26);

        // R10 unmapped address and truncation
        reg_write(3'd5, 32'hFFFF_FFFF);
        chk("R10", "mode after unmapped write", mode_rd, 8'h7E);
        reg_write(3'd1, 32'h0001_0002);
        frame_stats(per, ntx, nrx);
        chk("R10", "truncated on length", ntx, 3);
        chk("R10", "period after unmapped write", per, 21);

        // R5 hold
        reg_write(3'd0, 32'h01);
        @(negedge clk);
        quiet = 1'b1;
        for (int i = 0; i < 50; i++) begin
            if (tx_en || rx_window || pulse_start) quiet = 1'b0;
            @(negedge clk);
        end
        chk("R5", "quiet while held", quiet, 1);

        // R11 write while held
        reg_write(3'd3, 32'd0);
        reg_write(3'd0, 32'd0);
        frame_stats(per, ntx, nrx);
        chk("R11", "first frame period", per, 16);
        chk("R11", "first frame rx length", nrx, 1);
        chk("R2", "first frame tx length", ntx, 3);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule